// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides, for every memory or I/O transaction a PCI-to-PCI bridge sees, whether the bridge should claim it and carry it to the other side, and whether read data for it may be fetched ahead. It keeps the three address windows that software programs into the bridge: a 32-bit memory window, an I/O window, and a prefetchable memory window that can reach 64 bits. It also keeps three control bits: forced legacy display decode, palette write snoop, and prefetch of plain reads that arrive from the downstream side.

Each window is built from coarse register fields. Memory windows have a 1 MB step and the I/O window a 4 KB step. A transaction seen on the upstream (primary) side is claimed when it lands inside a window. A transaction seen on the downstream (secondary) side is claimed when it lands outside every window, so that it can be forwarded upstream. The decision is registered and appears one cycle after the request.

Top module: `brwin_decoder`

## Requirements
- R1: After reset every window is disabled (memory and prefetchable base field FFFh, limit 000h; I/O base nibble Fh, limit 0h; upper fields and control bits zero) and `resp_valid` is low. A primary request is then not claimed, and a secondary request is claimed.
- R2: `resp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and the response carries that request's decision. A register write in the same cycle as a request takes effect only for later requests.
- R3: Memory window: bits [15:4] written to selectors 0 (base) and 1 (limit) give address bits [31:20]. The window spans base with 20 low zero bits up to limit with 20 low one bits, and address bits [63:32] must be zero. For example, base 5550h and limit 5560h cover 55500000h to 556FFFFFh.
- R4: I/O window: bits [7:4] written to selectors 2 (base) and 3 (limit) give address bits [15:12], which is a 4 KB step. When the low nibble of the base write is 1h, the window is 32-bit and bits [31:16] come from selectors 4 (base) and 5 (limit). Otherwise it is 16-bit and address bits [31:16] must be zero.
- R5: Prefetchable window: bits [15:4] of selectors 6 (base) and 7 (limit) give address bits [31:20]. When the low nibble of the base write is 1h, bits [63:32] come from selectors 8 (base) and 9 (limit). Otherwise address bits [63:32] must be zero.
- R6: A window whose start address is above its end address matches nothing.
- R7: Memory requests (`req_io`=0) are compared against the memory and prefetchable windows, and I/O requests against the I/O window. On the primary side a hit is claimed. On the secondary side (`req_from_sec`=1) a hit is not claimed and a miss is claimed.
- R8: With control bit 0 set (selector 10), memory A0000h–BFFFFh and I/O addresses whose bits [9:0] are in 3B0h–3BBh or 3C0h–3DFh (with bits [63:16] zero) count as downstream hits whatever the windows hold.
- R9: With control bit 1 set and bit 0 clear, I/O writes whose address bits [9:0] are 3C6h, 3C8h or 3C9h (bits [63:16] zero) count as downstream hits. Reads of those addresses fall back to the windows alone.
- R10: Prefetch is allowed only for a claimed memory read. A line read (`req_kind`=1) or multiple read (`req_kind`=2) always qualifies. A plain read (`req_kind`=0) from the primary side qualifies only inside the prefetchable window. Writes never qualify.
- R11: A claimed plain memory read from the secondary side qualifies for prefetch only while control bit 2 is set. I/O requests never qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register selector (0–10) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Transaction address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | Read kind: 0 plain, 1 line, 2 multiple |
| req_from_sec | input | 1 | 1 = seen on secondary side |
| resp_valid | output | 1 | Decision for last cycle's request |
| resp_claim | output | 1 | Claim and forward |
| resp_prefetch | output | 1 | Read data may be prefetched |

## Verification
A register write and a decode can fall in the same cycle. The bench provokes this by moving the memory window in the same clock as a request whose address only the new window covers, and requires that request to follow the old window and the next one to follow the new window. A second overlap is palette snoop with forced display decode, where both rules claim the same I/O address. The bench judges by the read of a palette address, which must be claimed only when the forced display decode is on.

// File: rtl/brwin_pkg.sv
package brwin_pkg;

    localparam int ADDR_W    = 64;
    localparam int MEM_SHIFT = 20;
    localparam int IO_SHIFT  = 12;
    localparam int NWIN      = 3;
    localparam int WIN_MEM   = 0;
    localparam int WIN_IO    = 1;
    localparam int WIN_PF    = 2;

    typedef enum logic [3:0] {
        SEL_MEM_BASE   = 4'd0,
        SEL_MEM_LIMIT  = 4'd1,
        SEL_IO_BASE    = 4'd2,
        SEL_IO_LIMIT   = 4'd3,
        SEL_IO_BASE_U  = 4'd4,
        SEL_IO_LIMIT_U = 4'd5,
        SEL_PF_BASE    = 4'd6,
        SEL_PF_LIMIT   = 4'd7,
        SEL_PF_BASE_U  = 4'd8,
        SEL_PF_LIMIT_U = 4'd9,
        SEL_CTRL       = 4'd10
    } cfg_sel_e;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_LINE  = 2'd1,
        KIND_MULT  = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic [11:0] mem_base;
        logic [11:0] mem_limit;
        logic [3:0]  io_base;
        logic [3:0]  io_limit;
        logic        io_wide;
        logic [15:0] io_base_up;
        logic [15:0] io_limit_up;
        logic [11:0] pf_base;
        logic [11:0] pf_limit;
        logic        pf_wide;
        logic [31:0] pf_base_up;
        logic [31:0] pf_limit_up;
        logic        vga_en;
        logic        snoop_en;
        logic        sec_pf_en;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic claim;
        logic prefetch;
    } resp_t;

    function automatic logic [ADDR_W-1:0] mem_edge(input logic [11:0] field,
                                                   input logic [31:0] upper,
                                                   input logic wide,
                                                   input logic top);
        logic [MEM_SHIFT-1:0] fill;
        fill = top ? {MEM_SHIFT{1'b1}} : '0;
        return {(wide ? upper : 32'h0), field, fill};
    endfunction

    function automatic logic [ADDR_W-1:0] io_edge(input logic [3:0] field,
                                                  input logic [15:0] upper,
                                                  input logic wide,
                                                  input logic top);
        logic [IO_SHIFT-1:0] fill;
        fill = top ? {IO_SHIFT{1'b1}} : '0;
        return {32'h0, (wide ? upper : 16'h0), field, fill};
    endfunction

    function automatic logic legacy_mem(input logic [ADDR_W-1:0] a);
        return (a >= 64'h000A_0000) && (a <= 64'h000B_FFFF);
    endfunction

    function automatic logic legacy_io(input logic [ADDR_W-1:0] a);
        logic [9:0] low;
        low = a[9:0];
        return (a[ADDR_W-1:16] == '0) &&
               (((low >= 10'h3B0) && (low <= 10'h3BB)) ||
                ((low >= 10'h3C0) && (low <= 10'h3DF)));
    endfunction

    function automatic logic palette_io(input logic [ADDR_W-1:0] a);
        logic [9:0] low;
        low = a[9:0];
        return (a[ADDR_W-1:16] == '0) &&
               ((low == 10'h3C6) || (low == 10'h3C8) || (low == 10'h3C9));
    endfunction

endpackage

// File: rtl/brwin_regs.sv
module brwin_regs
    import brwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [3:0]  sel,
    input  logic [31:0] wdata,
    output cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg           <= '0;
            cfg.mem_base  <= 12'hFFF;
            cfg.io_base   <= 4'hF;
            cfg.pf_base   <= 12'hFFF;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_MEM_BASE:   cfg.mem_base    <= wdata[15:4];
                SEL_MEM_LIMIT:  cfg.mem_limit   <= wdata[15:4];
                SEL_IO_BASE: begin
                    cfg.io_base <= wdata[7:4];
                    cfg.io_wide <= (wdata[3:0] == 4'h1);
                end
                SEL_IO_LIMIT:   cfg.io_limit    <= wdata[7:4];
                SEL_IO_BASE_U:  cfg.io_base_up  <= wdata[15:0];
                SEL_IO_LIMIT_U: cfg.io_limit_up <= wdata[15:0];
                SEL_PF_BASE: begin
                    cfg.pf_base <= wdata[15:4];
                    cfg.pf_wide <= (wdata[3:0] == 4'h1);
                end
                SEL_PF_LIMIT:   cfg.pf_limit    <= wdata[15:4];
                SEL_PF_BASE_U:  cfg.pf_base_up  <= wdata;
                SEL_PF_LIMIT_U: cfg.pf_limit_up <= wdata;
                SEL_CTRL: begin
                    cfg.vga_en    <= wdata[0];
                    cfg.snoop_en  <= wdata[1];
                    cfg.sec_pf_en <= wdata[2];
                end
                default: ;
            endcase
        end
    end

    // R3: a memory base write is visible in the next cycle
    a_r3_mem_base_write: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 4'd0) |=> (cfg.mem_base == $past(wdata[15:4])));

    // R11: control bit 2 lands in the secondary prefetch enable
    a_r11_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 4'd10) |=> (cfg.sec_pf_en == $past(wdata[2])));

endmodule

// File: rtl/brwin_window.sv
module brwin_window
    import brwin_pkg::*;
#(
    parameter int W = ADDR_W
) (
    input  logic         active,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] addr,
    output logic         hit
);

    logic enabled;
    assign enabled = (lo <= hi);
    assign hit     = active && enabled && (addr >= lo) && (addr <= hi);

endmodule

// File: rtl/brwin_decoder.sv
module brwin_decoder
    import brwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    input  logic [63:0] req_addr,
    input  logic        req_io,
    input  logic        req_write,
    input  logic [1:0]  req_kind,
    input  logic        req_from_sec,
    output logic        resp_valid,
    output logic        resp_claim,
    output logic        resp_prefetch
);

    cfg_t cfg;
    resp_t resp_q;

    brwin_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    logic [NWIN-1:0][ADDR_W-1:0] win_lo;
    logic [NWIN-1:0][ADDR_W-1:0] win_hi;
    logic [NWIN-1:0]             win_active;
    logic [NWIN-1:0]             win_hit;

    always_comb begin
        win_lo[WIN_MEM]     = mem_edge(cfg.mem_base,  32'h0, 1'b0, 1'b0);
        win_hi[WIN_MEM]     = mem_edge(cfg.mem_limit, 32'h0, 1'b0, 1'b1);
        win_lo[WIN_IO]      = io_edge(cfg.io_base,  cfg.io_base_up,  cfg.io_wide, 1'b0);
        win_hi[WIN_IO]      = io_edge(cfg.io_limit, cfg.io_limit_up, cfg.io_wide, 1'b1);
        win_lo[WIN_PF]      = mem_edge(cfg.pf_base,  cfg.pf_base_up,  cfg.pf_wide, 1'b0);
        win_hi[WIN_PF]      = mem_edge(cfg.pf_limit, cfg.pf_limit_up, cfg.pf_wide, 1'b1);
        win_active[WIN_MEM] = !req_io;
        win_active[WIN_IO]  = req_io;
        win_active[WIN_PF]  = !req_io;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        brwin_window #(.W(ADDR_W)) u_win (
            .active (win_active[g]),
            .lo     (win_lo[g]),
            .hi     (win_hi[g]),
            .addr   (req_addr),
            .hit    (win_hit[g])
        );
    end

    logic legacy_hit, palette_hit, down_hit, claim_d, pf_d, burst_rd;

    always_comb begin
        legacy_hit  = cfg.vga_en &&
                      (req_io ? legacy_io(req_addr) : legacy_mem(req_addr));
        palette_hit = cfg.snoop_en && !cfg.vga_en && req_io && req_write &&
                      palette_io(req_addr);
        down_hit    = (|win_hit) || legacy_hit || palette_hit;
        claim_d     = req_from_sec ? !down_hit : down_hit;
        burst_rd    = (rd_kind_e'(req_kind) == KIND_LINE) ||
                      (rd_kind_e'(req_kind) == KIND_MULT);
        pf_d        = claim_d && !req_io && !req_write &&
                      (burst_rd ||
                       ((rd_kind_e'(req_kind) == KIND_PLAIN) &&
                        (req_from_sec ? cfg.sec_pf_en : win_hit[WIN_PF])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid    <= req_valid;
            resp_q.claim    <= req_valid && claim_d;
            resp_q.prefetch <= req_valid && pf_d;
        end
    end

    assign resp_valid    = resp_q.valid;
    assign resp_claim    = resp_q.claim;
    assign resp_prefetch = resp_q.prefetch;

    // R2: one response per request, one cycle later
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R11: I/O is never prefetched
    a_r11_io_no_prefetch: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_io) |=> !resp_prefetch);

    // R10: writes are never prefetched
    a_r10_write_no_prefetch: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !resp_prefetch);

    // R8: legacy display memory from the primary side is always claimed
    a_r8_legacy_mem_claim: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_from_sec && !req_io && cfg.vga_en &&
         req_addr >= 64'hA0000 && req_addr <= 64'hBFFFF) |=> resp_claim);

endmodule

// File: tb/sim_brwin_decoder.sv
module sim_brwin_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        req_io;
    logic        req_write;
    logic [1:0]  req_kind;
    logic        req_from_sec;
    logic        resp_valid;
    logic        resp_claim;
    logic        resp_prefetch;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    brwin_decoder u0 (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_io        (req_io),
        .req_write     (req_write),
        .req_kind      (req_kind),
        .req_from_sec  (req_from_sec),
        .resp_valid    (resp_valid),
        .resp_claim    (resp_claim),
        .resp_prefetch (resp_prefetch)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: valid/claim/prefetch actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rq(input string tag, input logic [63:0] a, input logic io,
                      input logic w, input logic [1:0] k, input logic sec,
                      input logic exp_claim, input logic exp_pf);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_io = io; req_write = w;
        req_kind = k; req_from_sec = sec;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {resp_valid, resp_claim, resp_prefetch}, {1'b1, exp_claim, exp_pf});
    endtask

    task automatic t_reset();
        check("R1 idle after reset", {resp_valid, resp_claim, resp_prefetch}, 3'b000);
        rq("R1 primary mem unclaimed", 64'h0000_1000, 0, 0, 0, 0, 0, 0);
        rq("R1 primary io unclaimed",  64'h0000_0000, 1, 0, 0, 0, 0, 0);
        rq("R1 secondary claimed",     64'h0000_1000, 0, 1, 0, 1, 1, 0);
    endtask

    task automatic t_mem();
        wr(4'd0, 32'h5550);
        wr(4'd1, 32'h5560);
        rq("R3 window start",     64'h5550_0000, 0, 1, 0, 0, 1, 0);
        rq("R3 window end",       64'h556F_FFFF, 0, 1, 0, 0, 1, 0);
        rq("R3 below start",      64'h554F_FFFF, 0, 1, 0, 0, 0, 0);
        rq("R3 above end",        64'h5570_0000, 0, 1, 0, 0, 0, 0);
        rq("R3 high bits set",    64'h1_5550_0000, 0, 1, 0, 0, 0, 0);
        rq("R7 io not in mem win",64'h5560_0000, 1, 1, 0, 0, 0, 0);
        rq("R7 secondary inside", 64'h5560_0000, 0, 1, 0, 1, 0, 0);
        rq("R7 secondary outside",64'h5570_0000, 0, 1, 0, 1, 1, 0);
    endtask

    task automatic t_same_cycle();
        // R2: write and request in the same cycle; request follows the old window
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'd1; cfg_wdata = 32'h5570;
        req_valid = 1'b1; req_addr = 64'h5575_0000; req_io = 0; req_write = 1;
        req_kind = 0; req_from_sec = 0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R2 same-cycle write uses old window", {resp_valid, resp_claim, resp_prefetch}, 3'b100);
        rq("R2 next request uses new window", 64'h5575_0000, 0, 1, 0, 0, 1, 0);
        @(negedge clk);
        check("R2 no response without request", {resp_valid, resp_claim, resp_prefetch}, 3'b000);
    endtask

    task automatic t_disable();
        wr(4'd0, 32'h5580);
        rq("R6 inverted window primary",   64'h5560_0000, 0, 1, 0, 0, 0, 0);
        rq("R6 inverted window secondary", 64'h5560_0000, 0, 1, 0, 1, 1, 0);
        wr(4'd0, 32'h5550);
        wr(4'd1, 32'h5560);
    endtask

    task automatic t_io();
        wr(4'd2, 32'h20);
        wr(4'd3, 32'h30);
        rq("R4 io16 start",      64'h2000, 1, 1, 0, 0, 1, 0);
        rq("R4 io16 end",        64'h3FFF, 1, 1, 0, 0, 1, 0);
        rq("R4 io16 above",      64'h4000, 1, 1, 0, 0, 0, 0);
        rq("R4 io16 below",      64'h1FFF, 1, 1, 0, 0, 0, 0);
        rq("R4 io16 bit16 set",  64'h1_2000, 1, 1, 0, 0, 0, 0);
        rq("R7 mem not in io win", 64'h2000, 0, 1, 0, 0, 0, 0);
        wr(4'd2, 32'h21);
        wr(4'd3, 32'h31);
        wr(4'd4, 32'h0001);
        wr(4'd5, 32'h0001);
        rq("R4 io32 inside",     64'h1_2000, 1, 1, 0, 0, 1, 0);
        rq("R4 io32 upper zero", 64'h0_2000, 1, 1, 0, 0, 0, 0);
        rq("R11 io read no prefetch", 64'h1_2000, 1, 0, 1, 0, 1, 0);
    endtask

    task automatic t_pf();
        wr(4'd6, 32'h8001);
        wr(4'd7, 32'h8FF1);
        wr(4'd8, 32'h2);
        wr(4'd9, 32'h2);
        rq("R5 pf64 start",       64'h2_8000_0000, 0, 1, 0, 0, 1, 0);
        rq("R5 pf64 end",         64'h2_8FFF_FFFF, 0, 1, 0, 0, 1, 0);
        rq("R5 pf64 upper wrong", 64'h0_8000_0000, 0, 1, 0, 0, 0, 0);
        rq("R10 plain read in pf win",  64'h2_8010_0000, 0, 0, 0, 0, 1, 1);
        rq("R10 plain read in mem win", 64'h5550_0000, 0, 0, 0, 0, 1, 0);
        rq("R10 line read mem win",     64'h5550_0000, 0, 0, 1, 0, 1, 1);
        rq("R10 multiple read mem win", 64'h5550_0000, 0, 0, 2, 0, 1, 1);
        rq("R10 unclaimed line read",   64'h7000_0000, 0, 0, 1, 0, 0, 0);
        rq("R10 write in pf win",       64'h2_8010_0000, 0, 1, 0, 0, 1, 0);
    endtask

    task automatic t_sec_pf();
        rq("R11 sec plain read bit clear", 64'h1000_0000, 0, 0, 0, 1, 1, 0);
        rq("R11 sec line read",            64'h1000_0000, 0, 0, 1, 1, 1, 1);
        wr(4'd10, 32'h4);
        rq("R11 sec plain read bit set",   64'h1000_0000, 0, 0, 0, 1, 1, 1);
        rq("R11 sec io read",              64'h0000_5000, 1, 0, 0, 1, 1, 0);
        wr(4'd10, 32'h0);
    endtask

    task automatic t_vga();
        rq("R8 legacy mem off", 64'hA0000, 0, 0, 0, 0, 0, 0);
        wr(4'd10, 32'h1);
        rq("R8 legacy mem low",   64'hA0000, 0, 0, 0, 0, 1, 0);
        rq("R8 legacy mem high",  64'hBFFFF, 0, 1, 0, 0, 1, 0);
        rq("R8 legacy mem above", 64'hC0000, 0, 1, 0, 0, 0, 0);
        rq("R8 io 3B0",           64'h3B0, 1, 0, 0, 0, 1, 0);
        rq("R8 io 3BC gap",       64'h3BC, 1, 0, 0, 0, 0, 0);
        rq("R8 io 3DF",           64'h3DF, 1, 1, 0, 0, 1, 0);
        rq("R8 io alias 7C0",     64'h7C0, 1, 1, 0, 0, 1, 0);
        rq("R8 secondary legacy", 64'hA0000, 0, 1, 0, 1, 0, 0);
    endtask

    task automatic t_snoop();
        wr(4'd10, 32'h2);
        rq("R9 palette write",       64'h3C8, 1, 1, 0, 0, 1, 0);
        rq("R9 palette read ignored",64'h3C8, 1, 0, 0, 0, 0, 0);
        rq("R9 palette alias write", 64'h7C9, 1, 1, 0, 0, 1, 0);
        rq("R9 non-palette write",   64'h3C7, 1, 1, 0, 0, 0, 0);
        rq("R9 secondary palette",   64'h3C6, 1, 1, 0, 1, 0, 0);
        wr(4'd10, 32'h3);
        rq("R9 read claimed with legacy on", 64'h3C8, 1, 0, 0, 0, 1, 0);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        req_valid = 0; req_addr = 0; req_io = 0; req_write = 0;
        req_kind = 0; req_from_sec = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mem();
        t_same_cycle();
        t_disable();
        t_io();
        t_pf();
        t_sec_pf();
        t_vga();
        t_snoop();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule